// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steers a multicycle processor datapath from a small fixed microprogram. A micro-program counter (micro-PC) selects one microinstruction per clock. Each microinstruction carries fields for the ALU function, the two ALU operand sources, the register-file action, the memory action, the PC update and the way the next address is chosen. A decode stage turns those fields into the individual datapath control lines, which are combinational functions of the current micro-PC.

The next micro-PC comes from one of four sources: the current address plus one, one of two opcode-indexed dispatch tables, or a jump back to the fetch entry. The microprogram has eight entries: fetch (0), decode (1), address compute (2), load read (3), load writeback (4), store (5), register-form execute (6) and branch-on-equal (7). The opcode input is only looked at in the two dispatch cycles. Opcode values are parameters; the defaults are register form 6'h00, load 6'h23, store 6'h2B and branch-on-equal 6'h04.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, upc is 0 and the outputs show the fetch controls.
- R2: At upc 0 the outputs are alu_op=0 (add), alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), mem_read=1, addr_sel=0 (PC), ir_load=1, pc_write=1, pc_src=0, all other controls 0. The next upc is 1 whatever the opcode.
- R3: At upc 1 the outputs are alu_op=0, alu_a_sel=0, alu_b_sel=3 (offset times 4), with every write and memory strobe 0. The next upc comes from the first dispatch table: load or store goes to 2, register form to 6, branch-on-equal to 7.
- R4: At upc 2 the outputs are alu_op=0, alu_a_sel=1 (A), alu_b_sel=2 (offset), with strobes 0. The next upc comes from the second dispatch table: load goes to 3, store goes to 5.
- R5: At upc 3 the outputs are mem_read=1 and addr_sel=1 (ALU result), and the next upc is 4. At upc 4 the outputs are reg_write=1, mem_to_reg=1 and reg_dst=0, and the next upc is 0.
- R6: At upc 5 the outputs are mem_write=1 and addr_sel=1, and the next upc is 0.
- R7: At upc 6 the outputs are alu_op=2 (funct field), alu_a_sel=1, alu_b_sel=0 (B), reg_write=1, reg_dst=1 and mem_to_reg=0, and the next upc is 0.
- R8: At upc 7 the outputs are alu_op=1 (subtract), alu_a_sel=1, alu_b_sel=0, pc_write_cond=1, pc_src=1 (latched branch target) and pc_write=0, and the next upc is 0.
- R9: An opcode that is not in the table consulted in a dispatch cycle sends the next upc to 0. This includes an opcode other than load or store at upc 2.
- R10: mem_read and mem_write are never both 1, and pc_write and pc_write_cond are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPC_W (6) | Opcode field of the instruction register |
| upc | output | UPC_W (4) | Current micro-program counter |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load when the ALU reports equality |
| pc_src | output | 1 | PC source: 0 ALU result, 1 latched ALU output |
| addr_sel | output | 1 | Memory address: 0 PC, 1 latched ALU output |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| reg_write | output | 1 | Register-file write |
| reg_dst | output | 1 | Write register: 0 rt field, 1 rd field |
| mem_to_reg | output | 1 | Write data: 0 ALU output, 1 memory data register |
| alu_a_sel | output | 1 | ALU input 1: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU input 2: 0 B, 1 four, 2 offset, 3 offset times 4 |
| alu_op | output | 2 | ALU function: 0 add, 1 subtract, 2 funct field |

## Verification
Every control output is a combinational decode of upc, so its value is due in the same cycle that upc holds an entry. The opcode decides upc exactly one rising edge after it is presented during a dispatch cycle, and it has no effect in any other cycle. The bench drives a new opcode on every falling edge and steps its own model of upc at the same moment. On the next falling edge it compares upc and the full control vector against the values that model predicts.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNCT = 2'd2} alu_fn_e;
   typedef enum logic {SRC1_PC = 1'b0, SRC1_A = 1'b1} src1_e;
   typedef enum logic [1:0] {SRC2_B = 2'd0, SRC2_FOUR = 2'd1, SRC2_IMM = 2'd2, SRC2_IMM_X4 = 2'd3} src2_e;
   typedef enum logic [1:0] {RF_IDLE = 2'd0, RF_READ = 2'd1, RF_WR_ALU = 2'd2, RF_WR_MDR = 2'd3} rf_e;
   typedef enum logic [1:0] {MEM_IDLE = 2'd0, MEM_RD_PC = 2'd1, MEM_RD_ALU = 2'd2, MEM_WR_ALU = 2'd3} mem_e;
   typedef enum logic [1:0] {PCW_NONE = 2'd0, PCW_ALU = 2'd1, PCW_TARGET_EQ = 2'd2} pcw_e;
   // Sequencing encoding: 0 fetch, 1 table one, 2 table two, 3 plus one
   typedef enum logic [1:0] {SEQ_FETCH = 2'd0, SEQ_DISP1 = 2'd1, SEQ_DISP2 = 2'd2, SEQ_NEXT = 2'd3} seq_e;

   typedef struct packed {
      alu_fn_e fn;
      src1_e   s1;
      src2_e   s2;
      rf_e     rf;
      mem_e    mem;
      pcw_e    pcw;
      seq_e    seq;
   } uinstr_t;

   // Named microprogram entries
   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_MEMADR = 2;
   localparam int UA_LDRD   = 3;
   localparam int UA_LDWB   = 4;
   localparam int UA_STWR   = 5;
   localparam int UA_REXEC  = 6;
   localparam int UA_BREQ   = 7;
   localparam int UA_COUNT  = 8;

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic [UPC_W-1:0] addr,
   output uinstr_t          word
);

   localparam int DEPTH = 1 << UPC_W;

   if (DEPTH < UA_COUNT) begin : g_chk_depth
      $error("useq_store: UPC_W too small for the microprogram");
   end

   function automatic uinstr_t entry(input int a);
      uinstr_t w;
      w = '{fn: ALU_ADD, s1: SRC1_PC, s2: SRC2_B, rf: RF_IDLE,
            mem: MEM_IDLE, pcw: PCW_NONE, seq: SEQ_FETCH};
      case (a)
         UA_FETCH: begin
            w.s2 = SRC2_FOUR; w.mem = MEM_RD_PC; w.pcw = PCW_ALU; w.seq = SEQ_NEXT;
         end
         UA_DECODE: begin
            w.s2 = SRC2_IMM_X4; w.rf = RF_READ; w.seq = SEQ_DISP1;
         end
         UA_MEMADR: begin
            w.s1 = SRC1_A; w.s2 = SRC2_IMM; w.seq = SEQ_DISP2;
         end
         UA_LDRD: begin
            w.mem = MEM_RD_ALU; w.seq = SEQ_NEXT;
         end
         UA_LDWB: begin
            w.rf = RF_WR_MDR;
         end
         UA_STWR: begin
            w.mem = MEM_WR_ALU;
         end
         UA_REXEC: begin
            w.fn = ALU_FUNCT; w.s1 = SRC1_A; w.rf = RF_WR_ALU;
         end
         UA_BREQ: begin
            w.fn = ALU_SUB; w.s1 = SRC1_A; w.pcw = PCW_TARGET_EQ;
         end
         default: ;
      endcase
      return w;
   endfunction

   always_comb word = entry(int'(addr));

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
   parameter int                         OPC_W   = 6,
   parameter int                         UPC_W   = 4,
   parameter int                         NKEY    = 2,
   parameter logic [NKEY*OPC_W-1:0]      KEYS    = '0,
   parameter logic [NKEY*UPC_W-1:0]      TARGETS = '0
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             hit,
   output logic [UPC_W-1:0] target
);

   if (NKEY < 1) begin : g_chk_nkey
      $error("useq_dispatch: table needs at least one key");
   end

   for (genvar i = 0; i < NKEY; i++) begin : g_uniq_i
      for (genvar j = i + 1; j < NKEY; j++) begin : g_uniq_j
         if (KEYS[i*OPC_W +: OPC_W] == KEYS[j*OPC_W +: OPC_W]) begin : g_dup
            $error("useq_dispatch: duplicate opcode key");
         end
      end
   end

   logic [NKEY-1:0] match;

   for (genvar g = 0; g < NKEY; g++) begin : g_key
      assign match[g] = (opcode == KEYS[g*OPC_W +: OPC_W]);
   end

   always_comb begin
      target = '0;
      for (int i = 0; i < NKEY; i++) begin
         if (match[i]) target = target | TARGETS[i*UPC_W +: UPC_W];
      end
   end

   assign hit = |match;

endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_e             seq,
   input  logic             d1_hit,
   input  logic [UPC_W-1:0] d1_tgt,
   input  logic             d2_hit,
   input  logic [UPC_W-1:0] d2_tgt,
   output logic [UPC_W-1:0] upc
);

   logic [UPC_W-1:0] nxt;

   always_comb begin
      case (seq)
         SEQ_FETCH: nxt = UPC_W'(UA_FETCH);
         SEQ_DISP1: nxt = d1_hit ? d1_tgt : UPC_W'(UA_FETCH);
         SEQ_DISP2: nxt = d2_hit ? d2_tgt : UPC_W'(UA_FETCH);
         SEQ_NEXT:  nxt = upc + UPC_W'(1);
         default:   nxt = UPC_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= UPC_W'(UA_FETCH);
      else        upc <= nxt;
   end

   // Missing opcode in either table falls back to fetch
   p_miss_to_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((seq == SEQ_DISP1 && !d1_hit) || (seq == SEQ_DISP2 && !d2_hit)) |=> (upc == UPC_W'(UA_FETCH)));

   p_plus_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SEQ_NEXT) |=> (upc == $past(upc) + UPC_W'(1)));

endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
(
   input  uinstr_t    word,
   output logic       pc_write,
   output logic       pc_write_cond,
   output logic       pc_src,
   output logic       addr_sel,
   output logic       mem_read,
   output logic       mem_write,
   output logic       ir_load,
   output logic       reg_write,
   output logic       reg_dst,
   output logic       mem_to_reg,
   output logic       alu_a_sel,
   output logic [1:0] alu_b_sel,
   output logic [1:0] alu_op
);

   always_comb begin
      alu_op        = word.fn;
      alu_a_sel     = word.s1;
      alu_b_sel     = word.s2;
      mem_read      = (word.mem == MEM_RD_PC) || (word.mem == MEM_RD_ALU);
      mem_write     = (word.mem == MEM_WR_ALU);
      addr_sel      = (word.mem == MEM_RD_ALU) || (word.mem == MEM_WR_ALU);
      ir_load       = (word.mem == MEM_RD_PC);
      reg_write     = (word.rf == RF_WR_ALU) || (word.rf == RF_WR_MDR);
      reg_dst       = (word.rf == RF_WR_ALU);
      mem_to_reg    = (word.rf == RF_WR_MDR);
      pc_write      = (word.pcw == PCW_ALU);
      pc_write_cond = (word.pcw == PCW_TARGET_EQ);
      pc_src        = (word.pcw == PCW_TARGET_EQ);
   end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int               OPC_W         = 6,
   parameter int               UPC_W         = 4,
   parameter logic [OPC_W-1:0] OPC_RTYPE     = 6'h00,
   parameter logic [OPC_W-1:0] OPC_LOAD      = 6'h23,
   parameter logic [OPC_W-1:0] OPC_STORE     = 6'h2B,
   parameter logic [OPC_W-1:0] OPC_BRANCH_EQ = 6'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output logic [UPC_W-1:0] upc,
   output logic             pc_write,
   output logic             pc_write_cond,
   output logic             pc_src,
   output logic             addr_sel,
   output logic             mem_read,
   output logic             mem_write,
   output logic             ir_load,
   output logic             reg_write,
   output logic             reg_dst,
   output logic             mem_to_reg,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       alu_op
);

   localparam int D1_N = 4;
   localparam int D2_N = 2;
   localparam logic [D1_N*OPC_W-1:0] D1_KEYS = {OPC_BRANCH_EQ, OPC_RTYPE, OPC_STORE, OPC_LOAD};
   localparam logic [D1_N*UPC_W-1:0] D1_TGTS = {UPC_W'(UA_BREQ), UPC_W'(UA_REXEC),
                                                UPC_W'(UA_MEMADR), UPC_W'(UA_MEMADR)};
   localparam logic [D2_N*OPC_W-1:0] D2_KEYS = {OPC_STORE, OPC_LOAD};
   localparam logic [D2_N*UPC_W-1:0] D2_TGTS = {UPC_W'(UA_STWR), UPC_W'(UA_LDRD)};

   if (OPC_W < 1) begin : g_chk_opc
      $error("useq_ctrl: OPC_W must be positive");
   end

   uinstr_t          word;
   logic             d1_hit, d2_hit;
   logic [UPC_W-1:0] d1_tgt, d2_tgt;

   useq_store #(.UPC_W(UPC_W)) u_store (.addr(upc), .word(word));

   useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W), .NKEY(D1_N), .KEYS(D1_KEYS), .TARGETS(D1_TGTS))
      u_disp1 (.opcode(opcode), .hit(d1_hit), .target(d1_tgt));

   useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W), .NKEY(D2_N), .KEYS(D2_KEYS), .TARGETS(D2_TGTS))
      u_disp2 (.opcode(opcode), .hit(d2_hit), .target(d2_tgt));

   useq_next #(.UPC_W(UPC_W)) u_next (
      .clk(clk), .rst_n(rst_n), .seq(word.seq),
      .d1_hit(d1_hit), .d1_tgt(d1_tgt), .d2_hit(d2_hit), .d2_tgt(d2_tgt),
      .upc(upc)
   );

   useq_decode u_dec (
      .word(word), .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_src(pc_src),
      .addr_sel(addr_sel), .mem_read(mem_read), .mem_write(mem_write), .ir_load(ir_load),
      .reg_write(reg_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
   );

   p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (upc == UPC_W'(UA_FETCH)));

   p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_FETCH)) |=> (upc == UPC_W'(UA_DECODE)));

   p_disp1_rtype_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_DECODE) && opcode == OPC_RTYPE) |=> (upc == UPC_W'(UA_REXEC)));

   p_disp2_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_MEMADR) && opcode == OPC_STORE) |=> (upc == UPC_W'(UA_STWR)));

   p_tail_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (upc >= UPC_W'(UA_LDWB) && upc <= UPC_W'(UA_BREQ)) |=> (upc == UPC_W'(UA_FETCH)));

   p_branch_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_BREQ)) |-> (pc_write_cond && pc_src && !reg_write));

   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_read && mem_write) && !(pc_write && pc_write_cond));

endmodule

// File: tb/useq_ctrl_test.sv
`timescale 1ns/1ps
module useq_ctrl_test;

   localparam logic [5:0] OP_R = 6'h00, OP_LD = 6'h23, OP_ST = 6'h2B, OP_BEQ = 6'h04;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;
   logic [3:0] upc;
   logic       pc_write, pc_write_cond, pc_src, addr_sel, mem_read, mem_write;
   logic       ir_load, reg_write, reg_dst, mem_to_reg, alu_a_sel;
   logic [1:0] alu_b_sel, alu_op;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int model = 0;
   bit last_miss = 1'b0;

   always #2.5 clk = ~clk;

   useq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
      .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_src(pc_src),
      .addr_sel(addr_sel), .mem_read(mem_read), .mem_write(mem_write), .ir_load(ir_load),
      .reg_write(reg_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
   );

   // {pc_write,pc_write_cond,pc_src,addr_sel,mem_read,mem_write,ir_load,
   //  reg_write,reg_dst,mem_to_reg,alu_a_sel,alu_b_sel,alu_op}
   function automatic logic [14:0] exp_ctl(input int u);
      case (u)
         0: return 15'b1_0_0_0_1_0_1_0_0_0_0_01_00;
         1: return 15'b0_0_0_0_0_0_0_0_0_0_0_11_00;
         2: return 15'b0_0_0_0_0_0_0_0_0_0_1_10_00;
         3: return 15'b0_0_0_1_1_0_0_0_0_0_0_00_00;
         4: return 15'b0_0_0_0_0_0_0_1_0_1_0_00_00;
         5: return 15'b0_0_0_1_0_1_0_0_0_0_0_00_00;
         6: return 15'b0_0_0_0_0_0_0_1_1_0_1_00_10;
         7: return 15'b0_1_1_0_0_0_0_0_0_0_1_00_01;
         default: return 15'b0;
      endcase
   endfunction

   function automatic int exp_next(input int u, input logic [5:0] op);
      case (u)
         0: return 1;
         1: if (op == OP_LD || op == OP_ST) return 2;
            else if (op == OP_R) return 6;
            else if (op == OP_BEQ) return 7;
            else return 0;
         2: if (op == OP_LD) return 3;
            else if (op == OP_ST) return 5;
            else return 0;
         3: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic string req_of(input int u, input bit miss);
      if (miss) return "R9";
      case (u)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3, 4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [14:0] act_ctl();
      return {pc_write, pc_write_cond, pc_src, addr_sel, mem_read, mem_write, ir_load,
              reg_write, reg_dst, mem_to_reg, alu_a_sel, alu_b_sel, alu_op};
   endfunction

   task automatic check_state(input string tag);
      checks++;
      if (int'(upc) != model || act_ctl() !== exp_ctl(model)) begin
         errors++;
         $display("FAIL %s upc=%0d ctl=%b expected upc=%0d ctl=%b",
                  tag, upc, act_ctl(), model, exp_ctl(model));
      end
      checks++;  // R10 strobe exclusivity
      if ((mem_read && mem_write) || (pc_write && pc_write_cond)) begin
         errors++;
         $display("FAIL R10 rd/wr=%b%b pcw/cond=%b%b expected no pair both high",
                  mem_read, mem_write, pc_write, pc_write_cond);
      end
   endtask

   // Called on a falling edge: check, present opcode, advance model
   task automatic step(input logic [5:0] op);
      check_state(req_of(model, last_miss));
      opcode = op;
      last_miss = ((model == 1 || model == 2) && exp_next(model, op) == 0);
      model = exp_next(model, op);
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [5:0] pick_op();
      case ($urandom % 8)
         0: return OP_LD;
         1: return OP_ST;
         2: return OP_R;
         3: return OP_BEQ;
         default: return 6'($urandom);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired, expected run to finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      model = 0;
      check_state("R1");            // R1 during reset
      rst_n = 1'b1;
      // Directed: load, store, register form, branch, each held steady
      repeat (5) step(OP_LD);
      repeat (4) step(OP_ST);
      repeat (3) step(OP_R);
      repeat (3) step(OP_BEQ);
      // R9: unknown opcode in table one
      repeat (2) step(6'h3F);
      // R9: register-form opcode arriving at table two
      step(OP_R);
      step(OP_LD);
      step(OP_R);
      // Opcode noise outside dispatch cycles is ignored (R2, R5)
      step(6'h3F);
      step(OP_LD);
      step(OP_LD);
      step(OP_BEQ);
      step(6'h15);
      step(OP_R);
      // Constrained random
      for (int i = 0; i < 1500; i++) step(pick_op());
      // R1: reset in the middle of an instruction
      rst_n = 1'b0;
      model = 0;
      last_miss = 1'b0;
      @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      step(OP_ST);                  // first cycle after release still fetch
      for (int i = 0; i < 300; i++) step(pick_op());
      check_state(req_of(model, last_miss));
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule